// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a 40-bit physical address for 4 KB pages. It follows a radix tree of four tables that live in ordinary memory. Each table is one 4 KB page of 512 entries, and each entry is 8 bytes wide. A request carries the virtual address, the kind of access (read, write or instruction fetch) and the privilege of the requester. The walker latches the request together with the root table frame. It then fetches one entry per level through a plain memory read port, and it waits for each read to return before it computes the next entry address.

Every entry the walker fetches is checked for presence, writability, user access and execute permission. The walk stops at the first entry that fails a check. The block then reports a fault code and the level at which the walk stopped. A walk that passes all four levels returns the leaf frame joined with the page offset. It also raises two flags: one asks for the accessed bit to be set, and on a write the other asks for the dirty bit to be set in the leaf. Writing those bits back to memory is left to the caller.

The control is a four-state machine:
- ST_IDLE goes to ST_ISSUE when a request arrives.
- ST_ISSUE goes to ST_WAIT after one cycle, in which the read is issued.
- ST_WAIT stays in place until the read data returns. It then goes back to ST_ISSUE for the next level, or to ST_DONE when the entry faults or is the leaf.
- ST_DONE returns to ST_IDLE after one cycle.

Top module: `pt_walker`

## Requirements
- R1: During and after reset, with no request made, `busy`, `done` and `mem_rd_en` are low.
- R2: Level n (n = 0..3) uses index bits VA[47-9n : 39-9n], so level 0 takes VA[47:39] and level 3 takes VA[20:12]. The entry address is {table frame, 9-bit index, 3'b000}. The level-0 table frame is the `root_frame` latched when the request is accepted. Each later table frame is bits [39:12] of the entry fetched one level above.
- R3: At most one read is outstanding. `mem_rd_en` is a one-cycle pulse, and no further pulse comes until `mem_rd_valid` has returned. A walk issues exactly (stopping level + 1) reads, which is 4 for a walk that succeeds.
- R4: An entry with bit 0 (present) clear ends the walk with fault code 1 (not present). `fault_level` gives the level index 0..3 of that entry.
- R5: When `req_user` = 1, an entry with bit 2 (user allowed) clear ends the walk with fault code 3 (user denied).
- R6: When `req_kind` = 1 (write), an entry with bit 1 (writable) clear ends the walk with fault code 2 (write denied).
- R7: When `req_kind` = 2 (fetch), an entry with bit 63 (no-execute) set ends the walk with fault code 4 (exec denied). Kinds 0 and 3 are reads. Within one entry the checks rank as follows: not present first, then user, then write, then exec. The walk stops at the first level where any check fails.
- R8: On success the results are fault code 0, `fault_level` = 3, `pa` = {leaf entry bits [39:12], VA[11:0]}, `set_accessed` = 1, and `set_dirty` = 1 exactly when the access is a write.
- R9: On any fault, `pa` = 0 and `set_accessed` = `set_dirty` = 0.
- R10: `done` is high for exactly one cycle. It rises in the cycle after the clock edge at which the last needed read data is taken. The results stay stable until the next walk completes.
- R11: A request presented while `busy` is high is ignored. A change of `root_frame` after the request has been accepted has no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request, taken only when idle |
| req_va | input | 48 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| req_user | input | 1 | 1 for a user-mode access, 0 for supervisor |
| root_frame | input | 28 | Frame number of the level-0 table |
| busy | output | 1 | High from acceptance until the end of the done cycle |
| mem_rd_en | output | 1 | One-cycle read request for an 8-byte entry |
| mem_rd_addr | output | 40 | Byte address of the entry being read |
| mem_rd_valid | input | 1 | Read data is present on mem_rd_data |
| mem_rd_data | input | 64 | Entry returned by memory |
| done | output | 1 | One-cycle pulse marking a finished walk |
| pa | output | 40 | Translated physical address, 0 on a fault |
| fault | output | 3 | 0 none, 1 not present, 2 write denied, 3 user denied, 4 exec denied |
| fault_level | output | 2 | Level of the stopping entry (3 on success) |
| set_accessed | output | 1 | Accessed bit must be set (success only) |
| set_dirty | output | 1 | Dirty bit must be set in the leaf (successful write) |

## Verification
Take a memory that raises `mem_rd_valid` L cycles after it sees `mem_rd_en`. Each level then costs one issue cycle plus L wait cycles. `done` therefore appears exactly (stopping level + 1) × (1 + L) cycles after the edge that accepts the request. The bench counts the clock edges from acceptance up to the first `done` it samples. It compares that count with the formula and reads every result in that same cycle. It repeats the whole vector table with L = 1 and L = 3. It checks one cycle later that `done` has dropped while the results are still held, and it counts the reads issued over each walk.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_READ2 = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_ABSENT = 3'd1,
        FLT_WRITE  = 3'd2,
        FLT_USER   = 3'd3,
        FLT_EXEC   = 3'd4
    } flt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_st_e;

    localparam int PTE_PRESENT = 0;
    localparam int PTE_WRITE   = 1;
    localparam int PTE_USER    = 2;
    localparam int PTE_NOEXEC  = 63;

endpackage

// File: rtl/pt_index_sel.sv
module pt_index_sel #(
    parameter int IDX_W   = 9,
    parameter int LEVELS  = 4,
    parameter int FRAME_W = 28,
    parameter int ENT_B   = 3,
    localparam int LVL_W  = $clog2(LEVELS),
    localparam int ADDR_W = FRAME_W + IDX_W + ENT_B
) (
    input  logic [LEVELS*IDX_W-1:0] va_idx_bits,
    input  logic [LVL_W-1:0]        level,
    input  logic [FRAME_W-1:0]      table_frame,
    output logic [ADDR_W-1:0]       entry_addr
);

    logic [IDX_W-1:0] idx_by_lvl [LEVELS];

    // level 0 takes the most significant index slice
    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign idx_by_lvl[g] = va_idx_bits[(LEVELS-1-g)*IDX_W +: IDX_W];
    end

    assign entry_addr = {table_frame, idx_by_lvl[level], {ENT_B{1'b0}}};

endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
    import pt_walker_pkg::*;
(
    input  logic       present,
    input  logic       writable,
    input  logic       user_ok,
    input  logic       no_exec,
    input  logic [1:0] kind,
    input  logic       user_mode,
    output flt_e       code
);

    // rank: absent, user, write, exec
    always_comb begin
        if (!present)                              code = FLT_ABSENT;
        else if (user_mode && !user_ok)            code = FLT_USER;
        else if ((kind == ACC_WRITE) && !writable) code = FLT_WRITE;
        else if ((kind == ACC_FETCH) && no_exec)   code = FLT_EXEC;
        else                                       code = FLT_NONE;
    end

    always_comb begin
        if (code == FLT_WRITE) begin
            a_r6_write_code_needs_write: assert (kind == ACC_WRITE);
        end
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VA_W   = 48,
    parameter int PA_W   = 40,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 9,
    parameter int LEVELS = 4,
    parameter int PTE_W  = 64,
    localparam int FRAME_W = PA_W - OFF_W,
    localparam int LVL_W   = $clog2(LEVELS),
    localparam int ENT_B   = $clog2(PTE_W / 8)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_va,
    input  logic [1:0]         req_kind,
    input  logic               req_user,
    input  logic [FRAME_W-1:0] root_frame,
    output logic               busy,
    output logic               mem_rd_en,
    output logic [PA_W-1:0]    mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [PTE_W-1:0]   mem_rd_data,
    output logic               done,
    output logic [PA_W-1:0]    pa,
    output logic [2:0]         fault,
    output logic [LVL_W-1:0]   fault_level,
    output logic               set_accessed,
    output logic               set_dirty
);

    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    walk_st_e           state_q, state_d;
    logic [VA_W-1:0]    va_q;
    logic [1:0]         kind_q;
    logic               user_q;
    logic [FRAME_W-1:0] frame_q;
    logic [LVL_W-1:0]   level_q;
    flt_e               chk_code;
    flt_e               fault_q;
    logic [LVL_W-1:0]   flvl_q;
    logic [PA_W-1:0]    pa_q;
    logic               acc_q, dirty_q;
    logic               rsp_take, walk_end;

    wire unused_pte_bits = ^{mem_rd_data[PTE_W-2:PA_W], mem_rd_data[OFF_W-1:3]};

    pt_index_sel #(
        .IDX_W  (IDX_W),
        .LEVELS (LEVELS),
        .FRAME_W(FRAME_W),
        .ENT_B  (ENT_B)
    ) u_idx (
        .va_idx_bits(va_q[VA_W-1:OFF_W]),
        .level      (level_q),
        .table_frame(frame_q),
        .entry_addr (mem_rd_addr)
    );

    pt_entry_check u_chk (
        .present  (mem_rd_data[PTE_PRESENT]),
        .writable (mem_rd_data[PTE_WRITE]),
        .user_ok  (mem_rd_data[PTE_USER]),
        .no_exec  (mem_rd_data[PTE_NOEXEC]),
        .kind     (kind_q),
        .user_mode(user_q),
        .code     (chk_code)
    );

    assign rsp_take = (state_q == ST_WAIT) && mem_rd_valid;
    assign walk_end = rsp_take && ((chk_code != FLT_NONE) || (level_q == LAST_LVL));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (walk_end) state_d = ST_DONE;
                      else if (rsp_take) state_d = ST_ISSUE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q    <= '0;
            kind_q  <= '0;
            user_q  <= 1'b0;
            frame_q <= '0;
            level_q <= '0;
            fault_q <= FLT_NONE;
            flvl_q  <= '0;
            pa_q    <= '0;
            acc_q   <= 1'b0;
            dirty_q <= 1'b0;
        end else begin
            if ((state_q == ST_IDLE) && req_valid) begin
                va_q    <= req_va;
                kind_q  <= req_kind;
                user_q  <= req_user;
                frame_q <= root_frame;
                level_q <= '0;
            end
            if (walk_end) begin
                fault_q <= chk_code;
                flvl_q  <= level_q;
                if (chk_code == FLT_NONE) begin
                    pa_q    <= {mem_rd_data[PA_W-1:OFF_W], va_q[OFF_W-1:0]};
                    acc_q   <= 1'b1;
                    dirty_q <= (kind_q == ACC_WRITE);
                end else begin
                    pa_q    <= '0;
                    acc_q   <= 1'b0;
                    dirty_q <= 1'b0;
                end
            end else if (rsp_take) begin
                frame_q <= mem_rd_data[PA_W-1:OFF_W];
                level_q <= level_q + 1'b1;
            end
        end
    end

    assign busy         = (state_q != ST_IDLE);
    assign mem_rd_en    = (state_q == ST_ISSUE);
    assign done         = (state_q == ST_DONE);
    assign pa           = pa_q;
    assign fault        = fault_q;
    assign fault_level  = flvl_q;
    assign set_accessed = acc_q;
    assign set_dirty    = dirty_q;

    a_r3_no_read_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !mem_rd_valid) |=> !mem_rd_en);

    a_r10_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_fault_clears_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault != 3'd0) |-> (pa == '0 && !set_accessed && !set_dirty));

    a_r8_dirty_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (done && set_dirty) |-> (set_accessed && kind_q == ACC_WRITE));

    a_r11_request_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(va_q));

    a_r4_absent_stops_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_take && !mem_rd_data[PTE_PRESENT]) |=> (done && fault == 3'd1));

endmodule

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [47:0] req_va = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic [27:0] root_frame = 28'h0000100;
    logic        busy, mem_rd_en, mem_rd_valid, done;
    logic [39:0] mem_rd_addr, pa;
    logic [63:0] mem_rd_data;
    logic [2:0]  fault;
    logic [1:0]  fault_level;
    logic        set_accessed, set_dirty;

    always #2.5 clk = ~clk;

    pt_walker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_kind(req_kind), .req_user(req_user), .root_frame(root_frame),
        .busy(busy), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .done(done),
        .pa(pa), .fault(fault), .fault_level(fault_level),
        .set_accessed(set_accessed), .set_dirty(set_dirty)
    );

    // ---------------- memory model ----------------
    logic [63:0] pmem [logic [39:0]];
    int          lat = 1;
    int          cnt = 0;
    int          rd_total = 0;
    int          overlap = 0;
    logic [63:0] data_q = '0;

    always @(posedge clk) begin
        if (mem_rd_en) begin
            if (cnt != 0) overlap <= overlap + 1;
            cnt      <= lat;
            rd_total <= rd_total + 1;
            data_q   <= pmem.exists(mem_rd_addr) ? pmem[mem_rd_addr] : 64'h0;
        end else if (cnt > 0) begin
            cnt <= cnt - 1;
        end
    end
    assign mem_rd_valid = (cnt == 1);
    assign mem_rd_data  = mem_rd_valid ? data_q : 64'h0;

    function automatic logic [63:0] mk(input logic [27:0] fr, input bit p, w, u, nx);
        logic [63:0] e = '0;
        e[39:12] = fr;
        e[0] = p; e[1] = w; e[2] = u; e[63] = nx;
        return e;
    endfunction

    task automatic put(input logic [27:0] tbl, input logic [8:0] idx, input logic [63:0] e);
        pmem[{tbl, idx, 3'b000}] = e;
    endtask

    function automatic logic [47:0] va_of(input logic [8:0] a, b, c, d, input logic [11:0] off);
        return {a, b, c, d, off};
    endfunction

    // ---------------- bookkeeping ----------------
    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string ftag(input logic [2:0] f);
        case (f)
            3'd1:    return "R4 not-present";
            3'd2:    return "R6 write-denied";
            3'd3:    return "R5 user-denied";
            3'd4:    return "R7 exec-denied";
            default: return "R8 success";
        endcase
    endfunction

    task automatic run_walk(input logic [47:0] va, input logic [1:0] kind, input logic user,
                            output int cyc, output int nrd);
        int rd0;
        @(negedge clk);
        req_va = va; req_kind = kind; req_user = user; req_valid = 1'b1;
        rd0 = rd_total;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        nrd = rd_total - rd0;
    endtask

    // ---------------- vector table ----------------
    typedef struct packed {
        logic [8:0]  i0, i1, i2, i3;
        logic [11:0] off;
        logic [1:0]  kind;
        logic        user;
        logic [2:0]  flt;
        logic [1:0]  lvl;
        logic [27:0] frame;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{9'd0,   9'd0, 9'd0, 9'd0,   12'h123, 2'd0, 1'b1, 3'd0, 2'd3, 28'hABCDE01},
        '{9'd0,   9'd0, 9'd0, 9'd0,   12'h123, 2'd1, 1'b1, 3'd0, 2'd3, 28'hABCDE01},
        '{9'd0,   9'd0, 9'd0, 9'd1,   12'hFFF, 2'd1, 1'b1, 3'd2, 2'd3, 28'h0},
        '{9'd0,   9'd0, 9'd0, 9'd1,   12'h000, 2'd0, 1'b1, 3'd0, 2'd3, 28'h1234567},
        '{9'd0,   9'd0, 9'd0, 9'd2,   12'h000, 2'd0, 1'b0, 3'd1, 2'd3, 28'h0},
        '{9'd3,   9'd0, 9'd0, 9'd0,   12'h000, 2'd0, 1'b0, 3'd1, 2'd0, 28'h0},
        '{9'd0,   9'd5, 9'd0, 9'd0,   12'h000, 2'd0, 1'b0, 3'd1, 2'd1, 28'h0},
        '{9'd1,   9'd0, 9'd0, 9'd0,   12'h007, 2'd1, 1'b0, 3'd2, 2'd0, 28'h0},
        '{9'd1,   9'd0, 9'd0, 9'd0,   12'h007, 2'd0, 1'b1, 3'd0, 2'd3, 28'h0000042},
        '{9'd2,   9'd0, 9'd0, 9'd0,   12'h000, 2'd0, 1'b1, 3'd3, 2'd0, 28'h0},
        '{9'd2,   9'd0, 9'd0, 9'd0,   12'h010, 2'd1, 1'b0, 3'd0, 2'd3, 28'h0000043},
        '{9'd511, 9'd0, 9'd0, 9'd0,   12'h000, 2'd2, 1'b0, 3'd4, 2'd0, 28'h0},
        '{9'd511, 9'd0, 9'd0, 9'd0,   12'h055, 2'd0, 1'b1, 3'd0, 2'd3, 28'h0000044},
        '{9'd0,   9'd0, 9'd0, 9'd3,   12'h000, 2'd2, 1'b1, 3'd4, 2'd3, 28'h0},
        '{9'd0,   9'd0, 9'd0, 9'd0,   12'h000, 2'd2, 1'b1, 3'd0, 2'd3, 28'hABCDE01},
        '{9'd0,   9'd0, 9'd0, 9'd511, 12'hFFF, 2'd1, 1'b1, 3'd0, 2'd3, 28'hFFFFFFF},
        '{9'd0,   9'd0, 9'd7, 9'd4,   12'h800, 2'd3, 1'b0, 3'd0, 2'd3, 28'h7777777},
        '{9'd0,   9'd0, 9'd1, 9'd0,   12'h000, 2'd0, 1'b0, 3'd1, 2'd2, 28'h0},
        '{9'd4,   9'd0, 9'd0, 9'd0,   12'h000, 2'd1, 1'b1, 3'd3, 2'd0, 28'h0}
    };

    initial begin : watchdog
        #500000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int cyc, nrd, levels, hold_pa;

        // level 0 (root 0x100)
        put(28'h100, 9'd0,   mk(28'h200, 1, 1, 1, 0));
        put(28'h100, 9'd1,   mk(28'h300, 1, 0, 1, 0));
        put(28'h100, 9'd2,   mk(28'h400, 1, 1, 0, 0));
        put(28'h100, 9'd4,   mk(28'h200, 1, 0, 0, 0));
        put(28'h100, 9'd511, mk(28'h500, 1, 1, 1, 1));
        // level 1
        put(28'h200, 9'd0, mk(28'h210, 1, 1, 1, 0));
        put(28'h300, 9'd0, mk(28'h310, 1, 1, 1, 0));
        put(28'h400, 9'd0, mk(28'h410, 1, 1, 1, 0));
        put(28'h500, 9'd0, mk(28'h510, 1, 1, 1, 0));
        // level 2
        put(28'h210, 9'd0, mk(28'h220, 1, 1, 1, 0));
        put(28'h210, 9'd7, mk(28'h230, 1, 1, 1, 0));
        put(28'h310, 9'd0, mk(28'h320, 1, 1, 1, 0));
        put(28'h410, 9'd0, mk(28'h420, 1, 1, 1, 0));
        put(28'h510, 9'd0, mk(28'h520, 1, 1, 1, 0));
        // level 3
        put(28'h220, 9'd0,   mk(28'hABCDE01, 1, 1, 1, 0));
        put(28'h220, 9'd1,   mk(28'h1234567, 1, 0, 1, 0));
        put(28'h220, 9'd3,   mk(28'h0FFFFFF, 1, 1, 1, 1));
        put(28'h220, 9'd511, mk(28'hFFFFFFF, 1, 1, 1, 0));
        put(28'h230, 9'd4,   mk(28'h7777777, 1, 1, 1, 0));
        put(28'h320, 9'd0,   mk(28'h0000042, 1, 1, 1, 0));
        put(28'h420, 9'd0,   mk(28'h0000043, 1, 1, 1, 0));
        put(28'h520, 9'd0,   mk(28'h0000044, 1, 1, 1, 0));

        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        chk("R1 done in reset", done, 0);
        chk("R1 rd_en in reset", mem_rd_en, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        chk("R1 rd_en after reset", mem_rd_en, 0);

        // vector table with two memory latencies
        foreach (VECS[k]) begin end
        for (int pass = 0; pass < 2; pass++) begin
            lat = (pass == 0) ? 1 : 3;
            for (int k = 0; k < NV; k++) begin
                vec_t v = VECS[k];
                logic [39:0] exp_pa;
                run_walk(va_of(v.i0, v.i1, v.i2, v.i3, v.off), v.kind, v.user, cyc, nrd);
                levels = (v.flt == 3'd0) ? 4 : int'(v.lvl) + 1;
                exp_pa = (v.flt == 3'd0) ? {v.frame, v.off} : 40'h0;
                chk({ftag(v.flt), " fault code"}, fault, v.flt);
                chk({ftag(v.flt), " level"}, fault_level, v.lvl);
                chk("R2 R8 R9 physical address", pa, exp_pa);
                chk("R8 R9 set_accessed", set_accessed, (v.flt == 3'd0));
                chk("R8 R9 set_dirty", set_dirty, (v.flt == 3'd0) && (v.kind == 2'd1));
                chk("R10 done latency", cyc, levels * (1 + lat));
                chk("R3 reads per walk", nrd, levels);
                @(negedge clk);
                chk("R10 done one cycle", done, 0);
                chk("R10 result held", pa, exp_pa);
            end
        end
        chk("R3 overlapping reads", overlap, 0);

        // R11: requests while busy ignored; root change after accept ignored
        lat = 2;
        @(negedge clk);
        req_va = va_of(9'd0, 9'd0, 9'd0, 9'd0, 12'h321); req_kind = 2'd0; req_user = 1'b1;
        req_valid = 1'b1;
        hold_pa = rd_total;
        @(negedge clk);
        req_va = va_of(9'd3, 9'd0, 9'd0, 9'd0, 12'h0); req_kind = 2'd1;
        root_frame = 28'h0999;
        cyc = 0;
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (cyc == 6) req_valid = 1'b0;
        end
        req_valid = 1'b0;
        root_frame = 28'h0000100;
        chk("R11 busy request ignored fault", fault, 0);
        chk("R11 busy request ignored pa", pa, {28'hABCDE01, 12'h321});
        chk("R11 latency unaffected", cyc, 4 * 3);
        nrd = rd_total;
        cyc = 0;
        for (int t = 0; t < 30; t++) begin
            @(negedge clk);
            if (done) cyc++;
        end
        chk("R11 no second walk done", cyc, 0);
        chk("R11 no extra reads", rd_total - nrd, 0);
        chk("R11 reads of first walk", nrd - hold_pa, 4);
        chk("R10 result still held", pa, {28'hABCDE01, 12'h321});

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule